// File: doc/BRIEF.md
# Clock Power-Down Output Gating Controller

This block sits between a clock synthesizer's output clocks and its output pads. A single shared input pin has two jobs. Right after reset the pin qualifies supply health. While it is low, the synthesizer stays off and every output is held in its stopped state. The first high sample of the pin means power is good. From then on the pin serves only as an asynchronous, active-high power-down request.

The request is synchronised to the controller clock. It has to be seen on two consecutive controller samples before shutdown begins, so a single-cycle glitch is ignored. Each output is stopped at a falling edge of its own clock, which means no runt pulses appear. Each differential output group has a drive-mode bit that picks its stopped levels. Single-ended outputs always park low.

When the request is released, the PLL is powered, and the block waits for the PLL lock indication. The outputs are then re-enabled one at a time, in a fixed order, one controller cycle apart. A timeout flag is raised if lock takes longer than a parameterised limit. The default limit is 1.8 ms at a 100 MHz controller clock.

Top module: `ckpd_ctrl`

## Requirements
- R1: After reset, the pin acts as a power-good qualifier. While it stays low, `pll_run_o` is 0 and all outputs remain stopped. Its first synchronised high sample starts the power-up sequence. Holding the pin high after that does not power the block down: a power-down request is recognised only after the pin has been seen low at least once in power-down mode.
- R2: A power-down request starts shutdown only if the synchronised pin is high on two consecutive controller clock samples. A high pulse lasting one controller cycle has no effect. Outputs keep running for at least three controller cycles after the pin rises.
- R3: A running differential output drives `diff_p_o` equal to its clock and `diff_n_o` equal to the inverse of its clock. A stopped group with drive-mode bit 1 drives p=0 and n=0. A stopped group with drive-mode bit 0 drives p=1 and n=0.
- R4: A single-ended output stops after a falling edge of its clock and is then held at 0. No output (`se_o` or `diff_n_o`) produces a high pulse shorter than half a clock period, whether it is stopping or being released.
- R5: `all_stopped_o` is 1 exactly when every output has been confirmed stopped. It is 1 out of reset and 0 while outputs run.
- R6: `pll_run_o` is 0 while the block waits for power-good and while it is powered down. It is 1 from power-good or request release until the next completed shutdown.
- R7: After power-good or request release, all outputs stay stopped until `pll_lock_i` is 1. They are then enabled one per controller cycle, in index order: differential groups 0 to N_DIFF-1 first, then the single-ended outputs. At every moment, the set of running outputs is a prefix of that order.
- R8: `lock_tmo_o` rises once the block has waited LOCK_TMO_CYC controller cycles for lock without getting it. It is cleared when the lock wait ends. The default LOCK_TMO_CYC is 180000, which equals 1.8 ms at 100 MHz.
- R9: A power-down request that arrives during the lock wait or during the staged enable returns the block to the powered-down state. Releasing the request again restarts the lock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| pwr_pin_i | input | 1 | Shared power-good / power-down request pin (asynchronous) |
| pll_lock_i | input | 1 | PLL lock indication |
| drive_mode_i | input | N_DIFF | Stop drive-mode bit per differential group |
| diff_clk_i | input | N_DIFF | Ungated clock of each differential group |
| se_clk_i | input | N_SE | Ungated clock of each single-ended output |
| pll_run_o | output | 1 | Power enable for the PLL, VCO and oscillator |
| all_stopped_o | output | 1 | All outputs confirmed stopped |
| lock_tmo_o | output | 1 | Lock wait exceeded its limit |
| diff_p_o | output | N_DIFF | Gated true side of each differential group |
| diff_n_o | output | N_DIFF | Gated complement side of each differential group |
| se_o | output | N_SE | Gated single-ended outputs |

## Verification
Some internal faults show up quickly at the ports. If the match history is wrong, a one-cycle glitch either shuts the outputs down or fails to. That is visible on the output clocks within about ten controller cycles. If the pin-function latch or the arming flag is wrong, the block powers down right after power-good, and `pll_run_o` falls within a few cycles. If the staging index or the enable vector is wrong, the prefix order breaks while outputs are being released. That is caught by sampling every output clock period during the release. A timeout counter that is off by more than a few cycles moves the rise of `lock_tmo_o` outside the window the bench expects. A drain that ends too early shows up as `all_stopped_o` being high while an output is still toggling.

// File: rtl/ckpd_pkg.sv
`timescale 1ns/1ps
package ckpd_pkg;
  typedef enum logic [2:0] {
    ST_PG_WAIT   = 3'd0,
    ST_RUN       = 3'd1,
    ST_STOPPING  = 3'd2,
    ST_OFF       = 3'd3,
    ST_LOCK_WAIT = 3'd4,
    ST_ENABLE    = 3'd5
  } seq_state_e;
endpackage

// File: rtl/ckpd_pin_front.sv
`timescale 1ns/1ps
// Shared-pin front end: synchroniser, function latch, arming and match history.
module ckpd_pin_front #(
  parameter int SYNC_STAGES = 2,
  parameter int MATCH_LEN   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pg_seen_o,
  output logic pd_req_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   smp;
  logic                   pd_mode_q, pd_mode_d;
  logic                   armed_q, armed_d;
  logic                   hit_now;
  logic [MATCH_LEN-2:0]   hist_q, hist_d;

  assign smp = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d    = {sync_q[SYNC_STAGES-2:0], pin_i};
    // first high sample flips the pin into request mode, permanently
    pd_mode_d = pd_mode_q | smp;
    // a request is only honoured after the pin was low in request mode
    armed_d   = armed_q | (pd_mode_q & ~smp);
  end

  assign hit_now = armed_q & smp;

  generate
    if (MATCH_LEN > 2) begin : g_long_hist
      always_comb hist_d = {hist_q[MATCH_LEN-3:0], hit_now};
    end else begin : g_short_hist
      always_comb hist_d = hit_now;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      pd_mode_q <= 1'b0;
      armed_q   <= 1'b0;
      hist_q    <= '0;
    end else begin
      sync_q    <= sync_d;
      pd_mode_q <= pd_mode_d;
      armed_q   <= armed_d;
      hist_q    <= hist_d;
    end
  end

  assign pg_seen_o = smp;
  assign pd_req_o  = hit_now & (&hist_q);

  // a request must follow a high sample one cycle earlier
  assert_req_two_samples_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req_o |-> $past(smp));
endmodule

// File: rtl/ckpd_seq.sv
`timescale 1ns/1ps
// Power sequencer: power-good wait, shutdown drain, lock wait, staged enable.
module ckpd_seq
  import ckpd_pkg::*;
#(
  parameter int N_GRP        = 5,
  parameter int LOCK_TMO_CYC = 180000,
  parameter int DRAIN_CYC    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_seen_i,
  input  logic             pd_req_i,
  input  logic             lock_i,
  input  logic [N_GRP-1:0] ack_i,
  output logic [N_GRP-1:0] grp_en_o,
  output logic             pll_run_o,
  output logic             all_stopped_o,
  output logic             lock_tmo_o
);
  localparam int IDX_W   = (N_GRP > 1) ? $clog2(N_GRP) : 1;
  localparam int CNT_MAX = (LOCK_TMO_CYC > DRAIN_CYC) ? LOCK_TMO_CYC : DRAIN_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] TMO_LAST   = CNT_W'(LOCK_TMO_CYC - 1);
  localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DRAIN_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(N_GRP - 1);

  seq_state_e       state_q, state_d;
  logic [N_GRP-1:0] en_q, en_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tmo_q, tmo_d;
  logic             none_running;

  assign none_running = (ack_i == '0);

  always_comb begin
    state_d = state_q;
    en_d    = en_q;
    idx_d   = idx_q;
    case (state_q)
      ST_PG_WAIT: begin
        en_d = '0;
        if (pg_seen_i) state_d = ST_LOCK_WAIT;
      end
      ST_LOCK_WAIT: begin
        en_d  = '0;
        idx_d = '0;
        if (pd_req_i)    state_d = ST_STOPPING;
        else if (lock_i) state_d = ST_ENABLE;
      end
      ST_ENABLE: begin
        if (pd_req_i) begin
          state_d = ST_STOPPING;
          en_d    = '0;
        end else begin
          en_d = en_q | (N_GRP'(1) << idx_q);
          if (idx_q == IDX_LAST) state_d = ST_RUN;
          else                   idx_d   = idx_q + 1'b1;
        end
      end
      ST_RUN: begin
        if (pd_req_i) begin
          state_d = ST_STOPPING;
          en_d    = '0;
        end
      end
      ST_STOPPING: begin
        en_d = '0;
        if (none_running && (cnt_q >= DRAIN_LAST)) state_d = ST_OFF;
      end
      ST_OFF: begin
        en_d = '0;
        if (!pd_req_i) state_d = ST_LOCK_WAIT;
      end
      default: begin
        state_d = ST_PG_WAIT;
        en_d    = '0;
      end
    endcase
  end

  // dwell counter restarts on every state change and saturates
  always_comb begin
    if (state_d != state_q)  cnt_d = '0;
    else if (cnt_q != '1)    cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
    tmo_d = (state_q == ST_LOCK_WAIT) && (state_d == ST_LOCK_WAIT)
            && (tmo_q || (cnt_q == TMO_LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PG_WAIT;
      en_q    <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      tmo_q   <= tmo_d;
    end
  end

  assign grp_en_o      = en_q;
  assign pll_run_o     = (state_q != ST_PG_WAIT) && (state_q != ST_OFF);
  assign all_stopped_o = none_running;
  assign lock_tmo_o    = tmo_q;

  assert_en_prefix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & (en_q + 1'b1)) == '0));
  assert_en_after_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q[0]) |-> $past(lock_i));
  assert_tmo_in_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> (state_q == ST_LOCK_WAIT));
  assert_off_all_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF) |-> (ack_i == '0));
endmodule

// File: rtl/ckpd_stop_sync.sv
`timescale 1ns/1ps
// Per-output clock-domain crossing: enable into the output clock domain,
// falling-edge run flag, rising-edge run flag, and confirmation back to clk.
module ckpd_stop_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gclk_i,
  input  logic en_i,
  output logic run_neg_o,
  output logic run_pos_o,
  output logic ack_o
);
  logic [1:0]             rsync_q;
  logic                   grst_n;
  logic [SYNC_STAGES-1:0] esync_q, esync_d;
  logic                   run_pos_q;
  logic [SYNC_STAGES-1:0] async_q, async_d;

  always_ff @(negedge gclk_i or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign grst_n = rsync_q[1];

  always_comb begin
    esync_d = {esync_q[SYNC_STAGES-2:0], en_i};
    async_d = {async_q[SYNC_STAGES-2:0], run_pos_q};
  end

  // enable changes take effect right after a falling edge of the output clock
  always_ff @(negedge gclk_i or negedge grst_n) begin
    if (!grst_n) esync_q <= '0;
    else         esync_q <= esync_d;
  end

  always_ff @(posedge gclk_i or negedge grst_n) begin
    if (!grst_n) run_pos_q <= 1'b0;
    else         run_pos_q <= esync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) async_q <= '0;
    else        async_q <= async_d;
  end

  assign run_neg_o = esync_q[SYNC_STAGES-1];
  assign run_pos_o = run_pos_q;
  assign ack_o     = async_q[SYNC_STAGES-1];

  // the rising-edge flag trails the falling-edge flag by half a period
  assert_pos_trails_neg_R4: assert property (@(posedge gclk_i) disable iff (!grst_n)
    1'b1 |=> (run_pos_q == $past(run_neg_o)));
endmodule

// File: rtl/ckpd_ctrl.sv
`timescale 1ns/1ps
module ckpd_ctrl #(
  parameter int N_DIFF       = 4,
  parameter int N_SE         = 1,
  parameter int SYNC_STAGES  = 2,
  parameter int MATCH_LEN    = 2,
  parameter int LOCK_TMO_CYC = 180000,
  parameter int DRAIN_CYC    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_pin_i,
  input  logic              pll_lock_i,
  input  logic [N_DIFF-1:0] drive_mode_i,
  input  logic [N_DIFF-1:0] diff_clk_i,
  input  logic [N_SE-1:0]   se_clk_i,
  output logic              pll_run_o,
  output logic              all_stopped_o,
  output logic              lock_tmo_o,
  output logic [N_DIFF-1:0] diff_p_o,
  output logic [N_DIFF-1:0] diff_n_o,
  output logic [N_SE-1:0]   se_o
);
  localparam int N_GRP = N_DIFF + N_SE;

  logic             pg_seen, pd_req;
  logic [N_GRP-1:0] grp_en, acks, run_neg, run_pos, gclk_all;

  assign gclk_all = {se_clk_i, diff_clk_i};

  ckpd_pin_front #(.SYNC_STAGES(SYNC_STAGES), .MATCH_LEN(MATCH_LEN)) u_front (
    .clk(clk), .rst_n(rst_n), .pin_i(pwr_pin_i),
    .pg_seen_o(pg_seen), .pd_req_o(pd_req)
  );

  ckpd_seq #(.N_GRP(N_GRP), .LOCK_TMO_CYC(LOCK_TMO_CYC), .DRAIN_CYC(DRAIN_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pg_seen_i(pg_seen), .pd_req_i(pd_req),
    .lock_i(pll_lock_i), .ack_i(acks), .grp_en_o(grp_en),
    .pll_run_o(pll_run_o), .all_stopped_o(all_stopped_o), .lock_tmo_o(lock_tmo_o)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_out
    ckpd_stop_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .gclk_i(gclk_all[g]), .en_i(grp_en[g]),
      .run_neg_o(run_neg[g]), .run_pos_o(run_pos[g]), .ack_o(acks[g])
    );
    if (g < N_DIFF) begin : g_diff
      // mode 1 parks both sides low, mode 0 parks p high and n low
      assign diff_p_o[g] = drive_mode_i[g] ? (diff_clk_i[g] & run_neg[g])
                                           : (diff_clk_i[g] | ~run_pos[g]);
      assign diff_n_o[g] = ~diff_clk_i[g] & run_pos[g];
    end else begin : g_se
      assign se_o[g-N_DIFF] = se_clk_i[g-N_DIFF] & run_neg[g] & run_pos[g];
    end
  end

  assert_pll_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_run_o |-> all_stopped_o);
endmodule

// File: tb/tb_ckpd_ctrl.sv
`timescale 1ns/1ps
module tb_ckpd_ctrl;
  localparam int TMO = 300;

  logic       clk, gclk, rst_n, pin, lock;
  logic [3:0] mode;
  logic       pll_run, all_stopped, tmo;
  logic [3:0] dp, dn;
  logic [0:0] se;
  int         checks, errors, runts;
  bit         mon_en;

  ckpd_ctrl #(.N_DIFF(4), .N_SE(1), .LOCK_TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_pin_i(pin), .pll_lock_i(lock),
    .drive_mode_i(mode), .diff_clk_i({4{gclk}}), .se_clk_i(gclk),
    .pll_run_o(pll_run), .all_stopped_o(all_stopped), .lock_tmo_o(tmo),
    .diff_p_o(dp), .diff_n_o(dn), .se_o(se)
  );

  initial begin clk = 1'b0; forever #5 clk = ~clk; end
  initial begin gclk = 1'b0; #2; forever #5 gclk = ~gclk; end

  // runt watch on every output that pulses high while gated (R4)
  wire [4:0] mon = {se, dn};
  for (genvar i = 0; i < 5; i++) begin : g_mon
    realtime rise_t;
    always @(posedge mon[i]) rise_t = $realtime;
    always @(negedge mon[i]) if (mon_en && ($realtime - rise_t < 4.0)) runts++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic at_high; @(posedge gclk); #2; endtask
  task automatic at_low;  @(negedge gclk); #2; endtask

  task automatic t_reset;
    at_high;
    chk(all_stopped == 1'b1, "R5 reset all_stopped", 32'(all_stopped), 1);
    chk(pll_run == 1'b0, "R6 reset pll_run", 32'(pll_run), 0);
    chk(tmo == 1'b0, "R8 reset timeout", 32'(tmo), 0);
    chk(dp == 4'hf && dn == 4'h0, "R3 mode0 stop high phase", {dp, dn}, 8'hf0);
    at_low;
    chk(dp == 4'hf && dn == 4'h0 && se == 1'b0, "R3 R4 stop low phase", {se, dp, dn}, 9'h0f0);
  endtask

  task automatic t_pg_wait;
    cyc(40);
    chk(pll_run == 1'b0, "R1 pin low keeps PLL off", 32'(pll_run), 0);
    chk(all_stopped == 1'b1, "R1 pin low keeps outputs stopped", 32'(all_stopped), 1);
    pin = 1'b1;
    cyc(6);
    chk(pll_run == 1'b1, "R1 R6 power-good starts PLL", 32'(pll_run), 1);
    cyc(40);
    chk(all_stopped == 1'b1, "R7 no enable without lock", 32'(all_stopped), 1);
    chk(pll_run == 1'b1, "R1 held-high pin is not a request", 32'(pll_run), 1);
  endtask

  task automatic t_enable_order;
    logic [4:0] v;
    int prev = 0;
    bit ok = 1'b1;
    mode = 4'hf;
    lock = 1'b1;
    for (int k = 0; k < 20; k++) begin
      at_high;
      v = {se, dp};
      if (((v & (v + 5'd1)) != 5'd0) || ($countones(v) < prev) || ($countones(v) > prev + 1))
        ok = 1'b0;
      prev = $countones(v);
    end
    chk(ok, "R7 release is one-at-a-time prefix order", 32'(v), 5'h1f);
    chk(v == 5'h1f, "R7 all outputs released", 32'(v), 5'h1f);
    chk(all_stopped == 1'b0, "R5 running clears all_stopped", 32'(all_stopped), 0);
    at_low;
    chk(dp == 4'h0 && dn == 4'hf && se == 1'b0, "R3 running low phase", {se, dp, dn}, 9'h00f);
    at_high;
    chk(dp == 4'hf && dn == 4'h0 && se == 1'b1, "R3 running high phase", {se, dp, dn}, 9'h1f0);
  endtask

  task automatic t_glitch;
    pin = 1'b0;
    cyc(6);
    pin = 1'b1;
    cyc(1);
    pin = 1'b0;
    cyc(20);
    chk(all_stopped == 1'b0, "R2 one-cycle pulse ignored", 32'(all_stopped), 0);
    at_high;
    chk({se, dp} == 5'h1f, "R2 outputs still toggling", {se, dp}, 5'h1f);
    chk(pll_run == 1'b1, "R2 PLL kept on after glitch", 32'(pll_run), 1);
  endtask

  task automatic t_powerdown;
    mode = 4'b0101;
    pin  = 1'b1;
    cyc(3);
    at_high;
    chk({se, dp} == 5'h1f, "R2 no stop before two samples", {se, dp}, 5'h1f);
    cyc(20);
    chk(all_stopped == 1'b1, "R5 shutdown confirmed", 32'(all_stopped), 1);
    chk(pll_run == 1'b0, "R6 PLL off when powered down", 32'(pll_run), 0);
    at_high;
    chk(dp == 4'b1010 && dn == 4'h0 && se == 1'b0, "R3 R4 mixed stop levels high", {se, dp, dn}, 9'h0a0);
    at_low;
    chk(dp == 4'b1010 && dn == 4'h0 && se == 1'b0, "R3 R4 mixed stop levels low", {se, dp, dn}, 9'h0a0);
  endtask

  task automatic t_lock_timeout;
    lock = 1'b0;
    pin  = 1'b0;
    cyc(6);
    chk(pll_run == 1'b1, "R6 release powers PLL", 32'(pll_run), 1);
    chk(all_stopped == 1'b1, "R7 stopped while waiting lock", 32'(all_stopped), 1);
    cyc(TMO - 30);
    chk(tmo == 1'b0, "R8 no timeout before limit", 32'(tmo), 0);
    cyc(50);
    chk(tmo == 1'b1, "R8 timeout after limit", 32'(tmo), 1);
  endtask

  task automatic t_pd_in_wait;
    pin = 1'b1;
    cyc(20);
    chk(pll_run == 1'b0, "R9 request in lock wait powers down", 32'(pll_run), 0);
    chk(tmo == 1'b0, "R8 timeout cleared on leaving wait", 32'(tmo), 0);
    chk(all_stopped == 1'b1, "R9 outputs stopped", 32'(all_stopped), 1);
    mode = 4'h0;
    lock = 1'b1;
    pin  = 1'b0;
    cyc(25);
    at_high;
    chk({se, dp} == 5'h1f, "R9 restart after release", {se, dp}, 5'h1f);
    at_low;
    chk(dn == 4'hf, "R9 complement side running", 32'(dn), 4'hf);
  endtask

  initial begin
    checks = 0; errors = 0; runts = 0; mon_en = 1'b0;
    rst_n = 1'b0; pin = 1'b0; lock = 1'b0; mode = 4'h0;
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    mon_en = 1'b1;
    t_reset;
    t_pg_wait;
    t_enable_order;
    t_glitch;
    t_powerdown;
    t_lock_timeout;
    t_pd_in_wait;
    chk(runts == 0, "R4 no runt pulses", 32'(runts), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule